// File: doc/BRIEF.md
# X.21 Line Clear Sequencer

This block runs the DTE side of clearing a call on an X.21 switched connection. A one-cycle clear command is checked against the line mode and the decoded call state. In switched mode with the line not yet ready, the block drives the clear request toward the network (call state 16). It then supervises the network's return to ready (call state 1) with a T5 timer that counts millisecond tick pulses. The outcome appears as a one-cycle interrupt strobe, together with a condition code, an interrupt status byte and a device status word.

There are three ways a command can end. If the line is already ready, the command completes at once with no clearing sequence. A command issued in leased-line mode is refused as a specification error. If the network does not reach ready before the T5 limit, the block reports an exception and marks a time-out in the status word. A command that arrives while a clear is in progress is ignored. The result registers keep their values until the next command is accepted.

Top module: `line_clear_seq`

## Requirements
- R1: With `switched` low, an accepted command raises `irq` on the next cycle with `cond_code`=2, `isb`=8'h08 (bit 3, specification check), `dev_status`=0, and `clr_req` stays low. This holds whatever the call state is.
- R2: With `switched` high and `call_state`≠1, an accepted command sets `clr_req` on the next cycle, gives no `irq`, and clears `cond_code`, `isb` and `dev_status` to 0.
- R3: While `clr_req` is high, `call_state`=1 ends the clear on the next cycle: `irq` pulses, `cond_code`=3, `isb`=0, `dev_status`=0, and `clr_req` falls.
- R4: If the clear is not completed, the edge that samples the T5_TICKS-th `tick_ms` pulse since the start ends the clear on the next cycle with `irq`, `cond_code`=2, `isb`=8'h01 (bit 0, device status available), and `dev_status`=16'hA000 (bits 15 and 13, T5 time-out). `clr_req` falls at the same time.
- R5: The clearing sequence starts from every call state value other than 1, including 0 and the maximum code.
- R6: With `switched` high and `call_state`=1, an accepted command raises `irq` on the next cycle with `cond_code`=3, `isb`=0 and `dev_status`=0, and `clr_req` never rises.
- R7: A command received while `clr_req` is high is ignored. `clr_req` stays high, the results stay 0, and the T5 count is not restarted.
- R8: `irq` is high for exactly one cycle. `cond_code`, `isb` and `dev_status` hold their values until the next accepted command.
- R9: If `call_state`=1 arrives on the same edge as the final T5 tick, the clear completes (`cond_code`=3) and no time-out is reported.
- R10: During and after reset, `clr_req`, `irq`, `cond_code`, `isb` and `dev_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_clear | input | 1 | One-cycle clear command strobe |
| switched | input | 1 | 1 = switched line, 0 = leased line |
| call_state | input | STATE_W | Decoded call state number (1 = ready) |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| clr_req | output | 1 | Drives the DTE clear request (call state 16) while a clear is in progress |
| irq | output | 1 | One-cycle interrupt strobe |
| cond_code | output | 2 | Condition code: 2 = exception, 3 = device end |
| isb | output | ISB_W | Interrupt status byte |
| dev_status | output | DSW_W | Device status word |

## Verification
The assertions take four things for granted. `tick_ms` is a single-cycle pulse. `cmd_clear` is a single-cycle strobe. `switched` and `call_state` change only between clock edges. Only one result is outstanding at a time. The stimulus drives every input on the falling edge and issues each command as a one-cycle pulse. It never changes `switched` during a clear. It moves `call_state` to 1 only where a completion or a shortcut is intended, and it produces ticks through a task that makes them one cycle wide.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_CLEAR = 1'b1
  } seq_t;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_REJECT  = 3'd1,
    EV_SHORT   = 3'd2,
    EV_START   = 3'd3,
    EV_DONE    = 3'd4,
    EV_TIMEOUT = 3'd5
  } ev_t;

  localparam logic [1:0] CC_NONE      = 2'd0;
  localparam logic [1:0] CC_EXCEPTION = 2'd2;
  localparam logic [1:0] CC_DEVEND    = 2'd3;

  localparam int ISB_DEVSTAT_BIT = 0;
  localparam int ISB_SPEC_BIT    = 3;
  localparam int DSW_T5_LO_BIT   = 13;
  localparam int DSW_T5_HI_BIT   = 15;

endpackage

// File: rtl/lcs_cmd_decode.sv
module lcs_cmd_decode
  import lcs_pkg::*;
#(
  parameter int STATE_W = 5
) (
  input  logic               cmd,
  input  logic               idle,
  input  logic               switched,
  input  logic [STATE_W-1:0] call_state,
  input  logic               t5_expire,
  output ev_t                ev
);

  localparam logic [STATE_W-1:0] READY_CODE = STATE_W'(1);

  logic line_ready;
  assign line_ready = (call_state == READY_CODE);

  always_comb begin
    ev = EV_NONE;
    if (idle) begin
      if (cmd) begin
        if (!switched)       ev = EV_REJECT;
        else if (line_ready) ev = EV_SHORT;
        else                 ev = EV_START;
      end
    end else begin
      if (line_ready)     ev = EV_DONE;
      else if (t5_expire) ev = EV_TIMEOUT;
    end
  end

endmodule

// File: rtl/lcs_t5_timer.sv
module lcs_t5_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expire
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end

  assign expire = run && tick && (cnt == LAST);

endmodule

// File: rtl/lcs_report.sv
module lcs_report
  import lcs_pkg::*;
#(
  parameter int ISB_W = 8,
  parameter int DSW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ev_t              ev,
  output logic             irq,
  output logic [1:0]       cc,
  output logic [ISB_W-1:0] isb,
  output logic [DSW_W-1:0] dsw
);

  logic [ISB_W-1:0] spec_mask;
  logic [ISB_W-1:0] devstat_mask;
  logic [DSW_W-1:0] t5_mask;

  for (genvar i = 0; i < ISB_W; i++) begin : g_isb
    assign spec_mask[i]    = (i == ISB_SPEC_BIT);
    assign devstat_mask[i] = (i == ISB_DEVSTAT_BIT);
  end

  for (genvar j = 0; j < DSW_W; j++) begin : g_dsw
    assign t5_mask[j] = (j == DSW_T5_LO_BIT) || (j == DSW_T5_HI_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      cc  <= CC_NONE;
      isb <= '0;
      dsw <= '0;
    end else begin
      irq <= 1'b0;
      case (ev)
        EV_REJECT: begin
          irq <= 1'b1;
          cc  <= CC_EXCEPTION;
          isb <= spec_mask;
          dsw <= '0;
        end
        EV_SHORT, EV_DONE: begin
          irq <= 1'b1;
          cc  <= CC_DEVEND;
          isb <= '0;
          dsw <= '0;
        end
        EV_START: begin
          cc  <= CC_NONE;
          isb <= '0;
          dsw <= '0;
        end
        EV_TIMEOUT: begin
          irq <= 1'b1;
          cc  <= CC_EXCEPTION;
          isb <= devstat_mask;
          dsw <= t5_mask;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/line_clear_seq.sv
module line_clear_seq
  import lcs_pkg::*;
#(
  parameter int T5_TICKS = 2000,
  parameter int STATE_W  = 5,
  parameter int ISB_W    = 8,
  parameter int DSW_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_clear,
  input  logic               switched,
  input  logic [STATE_W-1:0] call_state,
  input  logic               tick_ms,
  output logic               clr_req,
  output logic               irq,
  output logic [1:0]         cond_code,
  output logic [ISB_W-1:0]   isb,
  output logic [DSW_W-1:0]   dev_status
);

  seq_t state;
  ev_t  ev;
  logic t5_expire;

  lcs_cmd_decode #(.STATE_W(STATE_W)) u_dec (
    .cmd        (cmd_clear),
    .idle       (state == SEQ_IDLE),
    .switched   (switched),
    .call_state (call_state),
    .t5_expire  (t5_expire),
    .ev         (ev)
  );

  lcs_t5_timer #(.LIMIT(T5_TICKS)) u_t5 (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ev == EV_START),
    .run     (state == SEQ_CLEAR),
    .tick    (tick_ms),
    .expire  (t5_expire)
  );

  lcs_report #(.ISB_W(ISB_W), .DSW_W(DSW_W)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .irq   (irq),
    .cc    (cond_code),
    .isb   (isb),
    .dsw   (dev_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
    end else begin
      case (ev)
        EV_START:            state <= SEQ_CLEAR;
        EV_DONE, EV_TIMEOUT: state <= SEQ_IDLE;
        default:             state <= state;
      endcase
    end
  end

  assign clr_req = (state == SEQ_CLEAR);

endmodule

// File: rtl/lcs_chk.sv
module lcs_chk #(
  parameter int T5_TICKS = 2000,
  parameter int STATE_W  = 5,
  parameter int ISB_W    = 8,
  parameter int DSW_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_clear,
  input logic               switched,
  input logic [STATE_W-1:0] call_state,
  input logic               tick_ms,
  input logic               clr_req,
  input logic               irq,
  input logic [1:0]         cond_code,
  input logic [ISB_W-1:0]   isb,
  input logic [DSW_W-1:0]   dev_status
);

  localparam logic [STATE_W-1:0] READY_CODE = STATE_W'(1);

  int chk_ticks;
  always_ff @(posedge clk) begin
    if (!rst_n || !clr_req) chk_ticks <= 0;
    else if (tick_ms)       chk_ticks <= chk_ticks + 1;
  end

  logic at_last;
  assign at_last = clr_req && tick_ms && (chk_ticks == T5_TICKS - 1);

  a_r1_leased_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && !switched && !clr_req) |=> (irq && cond_code == 2'd2 && isb[3] && !clr_req));

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && switched && !clr_req && call_state != READY_CODE)
      |=> (clr_req && !irq && cond_code == 2'd0));

  a_r3_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && call_state == READY_CODE) |=> (irq && cond_code == 2'd3 && !clr_req));

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> (chk_ticks < T5_TICKS));

  a_r4_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && call_state != READY_CODE)
      |=> (irq && cond_code == 2'd2 && dev_status[13] && dev_status[15] && !clr_req));

  a_r6_short: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clear && switched && !clr_req && call_state == READY_CODE)
      |=> (irq && cond_code == 2'd3 && !clr_req));

  a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && cmd_clear && call_state != READY_CODE && !at_last) |=> (clr_req && !irq));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !cmd_clear) |=> ($stable(cond_code) && $stable(isb) && $stable(dev_status)));

endmodule

bind line_clear_seq lcs_chk #(
  .T5_TICKS (T5_TICKS),
  .STATE_W  (STATE_W),
  .ISB_W    (ISB_W),
  .DSW_W    (DSW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_clear  (cmd_clear),
  .switched   (switched),
  .call_state (call_state),
  .tick_ms    (tick_ms),
  .clr_req    (clr_req),
  .irq        (irq),
  .cond_code  (cond_code),
  .isb        (isb),
  .dev_status (dev_status)
);

// File: tb/sim_line_clear_seq.sv
module sim_line_clear_seq;

  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_clear;
  logic        switched;
  logic [4:0]  call_state;
  logic        tick_ms;
  logic        clr_req;
  logic        irq;
  logic [1:0]  cond_code;
  logic [7:0]  isb;
  logic [15:0] dev_status;

  always #2 clk = ~clk;

  line_clear_seq #(.T5_TICKS(LIM)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_clear  (cmd_clear),
    .switched   (switched),
    .call_state (call_state),
    .tick_ms    (tick_ms),
    .clr_req    (clr_req),
    .irq        (irq),
    .cond_code  (cond_code),
    .isb        (isb),
    .dev_status (dev_status)
  );

  typedef struct {
    int          at;
    logic [1:0]  cc;
    logic [7:0]  isb;
    logic [15:0] dsw;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  logic irq_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input int at, input logic [1:0] cc, input logic [7:0] ib,
                      input logic [15:0] dw, input string tag);
    exp_t e;
    e.at = at; e.cc = cc; e.isb = ib; e.dsw = dw; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq && irq_prev) check(1'b0, "R8", "irq wider than one cycle", 1, 0);
      if (irq) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "unexpected irq", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.at, e.tag, "irq cycle", cyc, e.at);
          check(cond_code == e.cc, e.tag, "cond_code", cond_code, e.cc);
          check(isb == e.isb, e.tag, "isb", isb, e.isb);
          check(dev_status == e.dsw, e.tag, "dev_status", dev_status, e.dsw);
        end
      end
    end
    irq_prev <= irq;
  end

  task automatic pulse_cmd();
    cmd_clear = 1'b1;
    @(negedge clk);
    cmd_clear = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic start_clear(input logic [4:0] st, input string tag);
    call_state = st;
    pulse_cmd();
    check(clr_req == 1'b1, tag, "clr_req after start", clr_req, 1);
    check(cond_code == 2'd0, "R2", "cond_code cleared at start", cond_code, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_clear = 1'b0; switched = 1'b1;
    call_state = 5'd8; tick_ms = 1'b0;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(clr_req == 0 && irq == 0, "R10", "clr_req/irq in reset", {clr_req, irq}, 0);
    check(cond_code == 0 && isb == 0 && dev_status == 0, "R10", "results in reset",
          {cond_code, isb, dev_status}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 leased rejection, line not ready and line ready
    switched = 1'b0;
    for (int k = 0; k < 2; k++) begin
      call_state = (k == 0) ? 5'd8 : 5'd1;
      push(cyc + 1, 2'd2, 8'h08, 16'h0000, "R1");
      pulse_cmd();
      check(clr_req == 1'b0, "R1", "clr_req on reject", clr_req, 0);
      repeat (3) @(negedge clk);
      check(cond_code == 2'd2 && isb == 8'h08, "R8", "hold after reject", {cond_code, isb}, 10'h208);
    end
    switched = 1'b1;

    // R6 shortcut
    call_state = 5'd1;
    push(cyc + 1, 2'd3, 8'h00, 16'h0000, "R6");
    pulse_cmd();
    check(clr_req == 1'b0, "R6", "no clear on shortcut", clr_req, 0);
    @(negedge clk);

    // R3 / R5 completion from various call states
    for (int k = 0; k < 4; k++) begin
      logic [4:0] st;
      case (k)
        0: st = 5'd8;
        1: st = 5'd0;
        2: st = 5'd19;
        default: st = 5'd31;
      endcase
      start_clear(st, "R5");
      repeat (3) @(negedge clk);
      check(clr_req == 1'b1, "R5", "clear held while waiting", clr_req, 1);
      push(cyc + 1, 2'd3, 8'h00, 16'h0000, "R3");
      call_state = 5'd1;
      @(negedge clk);
      check(clr_req == 1'b0, "R3", "clr_req after completion", clr_req, 0);
      call_state = 5'd8;
      @(negedge clk);
    end

    // R4 time-out
    start_clear(5'd8, "R2");
    ticks(LIM - 1);
    check(clr_req == 1'b1, "R4", "still clearing before limit", clr_req, 1);
    push(cyc + 1, 2'd2, 8'h01, 16'hA000, "R4");
    tick_ms = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0;
    check(clr_req == 1'b0, "R4", "clr_req after time-out", clr_req, 0);
    repeat (2) @(negedge clk);
    check(dev_status == 16'hA000, "R8", "status hold after time-out", dev_status, 16'hA000);

    // R7 command during clear ignored, timer not restarted
    start_clear(5'd8, "R2");
    ticks(10);
    pulse_cmd();
    check(clr_req == 1'b1 && cond_code == 2'd0, "R7", "ignored command", {clr_req, cond_code}, 3'b100);
    ticks(LIM - 11);
    check(clr_req == 1'b1, "R7", "still clearing", clr_req, 1);
    push(cyc + 1, 2'd2, 8'h01, 16'hA000, "R7");
    tick_ms = 1'b1;
    @(negedge clk);
    tick_ms = 1'b0;
    check(clr_req == 1'b0, "R7", "time-out at original limit", clr_req, 0);
    @(negedge clk);

    // R9 completion wins over simultaneous final tick
    start_clear(5'd2, "R5");
    ticks(LIM - 1);
    push(cyc + 1, 2'd3, 8'h00, 16'h0000, "R9");
    tick_ms = 1'b1;
    call_state = 5'd1;
    @(negedge clk);
    tick_ms = 1'b0;
    check(cond_code == 2'd3 && dev_status == 0, "R9", "completion over time-out",
          {cond_code, dev_status}, {2'd3, 16'h0});

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R8", "all expected interrupts seen", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule